// File: doc/BRIEF.md
# Host-Programmable Color Palette Register Bank

This block is a small slave register file sitting between a host processor and a pixel pipeline. The host writes a mode byte and sixteen color entries through a strobed register interface: an access strobe, a direction line, separate write and read data buses, and a register-select bus fed from the host's lowest address bits. The pixel pipeline presents a 4-bit pixel value and receives, in the same cycle, the color the host programmed for that value. This lets each nibble of a 16-color frame be shown as any of 64 colors.

Each color entry is six bits with two bits per primary: blue in bits 5:4, green in bits 3:2, red in bits 1:0. The mode byte is stored whole and presented to the rest of the video path. Writes land on a rising clock edge. Host reads and pixel lookups are both combinational, so the two read paths never wait on each other.

Top module: `palette_regbank`

## Requirements
- R1: After a synchronous active-high reset the mode register and all sixteen color entries are zero, and `pix_color` is zero for every pixel value.
- R2: On a rising edge with `host_cs`=1, `host_wr`=1 and `host_sel`=0, all eight bits of `host_din` are stored in the mode register, visible on `mode_out` after that edge.
- R3: On a rising edge with `host_cs`=1, `host_wr`=1 and `host_sel`=k with 1 <= k <= 16, `host_din[5:0]` is stored as color entry k-1 (blue 5:4, green 3:2, red 1:0); bits 7:6 of `host_din` are discarded, and no other entry or the mode register changes.
- R4: With `host_cs`=0 no register changes, whatever `host_wr`, `host_sel` and `host_din` carry.
- R5: While `host_cs`=1 and `host_wr`=0, `host_dout` shows the register chosen by `host_sel` in the same cycle: the mode byte for select 0, and the color entry with bits 7:6 reading zero for selects 1 to 16.
- R6: `host_dout` is zero whenever `host_cs`=0 or `host_wr`=1.
- R7: `pix_color` equals the color entry indexed by `pix_idx` combinationally; a write to that entry appears on `pix_color` immediately after the clock edge that stores it, and not before.
- R8: Selects 17 to 31 address nothing: writes there change no register, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Access strobe; a transfer happens only while high |
| host_wr | input | 1 | Direction: 1 = write, 0 = read |
| host_sel | input | 5 | Register select from low host address bits |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data, zero when no read is active |
| pix_idx | input | 4 | Pixel value to translate |
| pix_color | output | 6 | Programmed color for `pix_idx`, BBGGRR |
| mode_out | output | 8 | Stored mode byte |

## Verification
The hardest situation to reach from the ports is the exact cycle in which a pixel lookup and a host write hit the same entry: the old color must still show before the storing edge and the new one right after it. The bench parks `pix_idx` on an entry, drives a write to that entry on the falling edge, samples `pix_color` just before and just after the next rising edge, and compares both against its own model. It also drives every unmapped select with all-ones data and then sweeps every pixel value to prove nothing moved.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Direction encoding on the host direction line.
  typedef enum logic {
    HOST_RD = 1'b0,
    HOST_WR = 1'b1
  } host_dir_e;

  // Select value of the mode register; palette entries follow it.
  localparam int unsigned MODE_SEL = 0;
  localparam int unsigned PAL_BASE = 1;
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
  parameter int unsigned SEL_W = 5,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  output logic             mode_we,
  output logic             pal_we,
  output logic             mode_rd,
  output logic             pal_rd,
  output logic [IDX_W-1:0] pal_idx
);
  import pal_pkg::*;

  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(MODE_SEL);
  localparam logic [SEL_W-1:0] SEL_FIRST = SEL_W'(PAL_BASE);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(PAL_BASE + ENTRIES - 1);

  logic             hit_mode;
  logic             hit_pal;
  logic [SEL_W-1:0] offset;
  logic             do_wr;
  logic             do_rd;

  always_comb begin
    hit_mode = (sel == SEL_MODE);
    hit_pal  = (sel >= SEL_FIRST) && (sel <= SEL_LAST);
    offset   = sel - SEL_FIRST;
    pal_idx  = offset[IDX_W-1:0];
    do_wr    = cs && (wr == HOST_WR);
    do_rd    = cs && (wr == HOST_RD);
    mode_we  = do_wr && hit_mode;
    pal_we   = do_wr && hit_pal;
    mode_rd  = do_rd && hit_mode;
    pal_rd   = do_rd && hit_pal;
  end

  // R4: no write strobe reaches storage without the access strobe
  p_we_needs_cs_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_we || pal_we) |-> (cs && wr));

  // R8: at most one target per access, none for unmapped selects
  p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_we, pal_we, mode_rd, pal_rd}));
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned COLOR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [IDX_W-1:0]   pix_ridx,
  output logic [COLOR_W-1:0] pix_rdata,
  input  logic [IDX_W-1:0]   host_ridx,
  output logic [COLOR_W-1:0] host_rdata
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0][COLOR_W-1:0] ent;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[g] <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        ent[g] <= wdata;
      end
    end
  end

  // Two independent asynchronous read ports.
  always_comb begin
    pix_rdata  = ent[pix_ridx];
    host_rdata = ent[host_ridx];
  end

  // R3: a write lands in the addressed entry
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> (ent[$past(widx)] == $past(wdata)));

  // R4: with no write, the whole table holds
  p_table_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ent));

  // R1: reset clears every entry
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (ent == '0));
endmodule

// File: rtl/palette_regbank.sv
module palette_regbank #(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COLOR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [COLOR_W-1:0] pix_color,
  output logic [DATA_W-1:0] mode_out
);
  localparam int unsigned PAD_W = DATA_W - COLOR_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic               mode_we;
  logic               pal_we;
  logic               mode_rd;
  logic               pal_rd;
  logic [IDX_W-1:0]   pal_idx;
  logic [COLOR_W-1:0] host_color;
  logic [DATA_W-1:0]  mode_q;

  pal_decode #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .cs      (host_cs),
    .wr      (host_wr),
    .sel     (host_sel),
    .mode_we (mode_we),
    .pal_we  (pal_we),
    .mode_rd (mode_rd),
    .pal_rd  (pal_rd),
    .pal_idx (pal_idx)
  );

  pal_store #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .we         (pal_we),
    .widx       (pal_idx),
    .wdata      (host_din[COLOR_W-1:0]),
    .pix_ridx   (pix_idx),
    .pix_rdata  (pix_color),
    .host_ridx  (pal_idx),
    .host_rdata (host_color)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= host_din;
    end
  end

  assign mode_out = mode_q;

  always_comb begin
    host_dout = '0;
    if (mode_rd) begin
      host_dout = mode_q;
    end else if (pal_rd) begin
      host_dout = {{PAD_W{1'b0}}, host_color};
    end
  end

  // R6: the read bus is quiet unless a read is strobed
  p_dout_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(host_cs && !host_wr) |-> (host_dout == '0));

  // R2: a mode write is seen on the mode output after the edge
  p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && (host_sel == '0)) |=> (mode_out == $past(host_din)));

  // R8: reads above the palette return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_wr && (host_sel > SEL_W'(ENTRIES))) |-> (host_dout == '0));

  // R4: mode holds without a strobed write to it
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !host_cs |=> $stable(mode_out));

  // R5: palette reads never set the pad bits
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_wr && (host_sel != '0)) |-> (host_dout[DATA_W-1:COLOR_W] == '0));
endmodule

// File: tb/palette_regbank_test.sv
`timescale 1ns/1ps
module palette_regbank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_cs = 1'b0;
  logic       host_wr = 1'b0;
  logic [4:0] host_sel = '0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic [3:0] pix_idx = '0;
  logic [5:0] pix_color;
  logic [7:0] mode_out;

  int total = 0;
  int bad = 0;

  logic [5:0] exp_pal [16];
  logic [7:0] exp_mode;

  always #2.5 clk = ~clk;

  palette_regbank uut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_wr(host_wr),
    .host_sel(host_sel), .host_din(host_din), .host_dout(host_dout),
    .pix_idx(pix_idx), .pix_color(pix_color), .mode_out(mode_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0; host_sel = '0; host_din = '0;
  endtask

  task automatic host_write(input logic [4:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_sel = sel; host_din = d;
    @(posedge clk); #1;
    if (sel == 0) exp_mode = d;
    else if (sel <= 16) exp_pal[sel - 1] = d[5:0];
    idle();
  endtask

  task automatic host_read(input logic [4:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b0; host_sel = sel;
    #1 d = host_dout;
    idle();
  endtask

  task automatic sweep_pixels(input string req);
    for (int i = 0; i < 16; i++) begin
      pix_idx = 4'(i); #0.2;
      chk(req, {2'b00, pix_color}, {2'b00, exp_pal[i]});
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #0.5;
    chk("R1 mode after reset", mode_out, 8'h00);
    chk("R1 dout idle after reset", host_dout, 8'h00);
    sweep_pixels("R1 pixel color after reset");
  endtask

  task automatic t_mode();
    logic [7:0] d;
    host_write(5'd0, 8'hA5);
    chk("R2 mode output", mode_out, 8'hA5);
    host_read(5'd0, d);
    chk("R5 mode readback", d, 8'hA5);
    host_write(5'd0, 8'h3C);
    chk("R2 mode rewrite", mode_out, 8'h3C);
  endtask

  task automatic t_palette();
    logic [7:0] d;
    for (int k = 0; k < 16; k++) host_write(5'(k + 1), 8'hC0 | 8'((k * 7 + 3) & 63));
    sweep_pixels("R3 R7 pixel lookup");
    host_read(5'd1, d);
    chk("R5 entry 0 readback", d, {2'b00, exp_pal[0]});
    host_read(5'd16, d);
    chk("R5 entry 15 readback bits 7:6 zero", d, {2'b00, exp_pal[15]});
    host_read(5'd9, d);
    chk("R3 upper bits dropped", d, 8'((8 * 7 + 3) & 63));
    chk("R3 mode untouched by palette writes", mode_out, exp_mode);
  endtask

  task automatic t_no_cs();
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b1; host_sel = 5'd3; host_din = 8'hFF;
    @(posedge clk);
    host_sel = 5'd0;
    @(posedge clk); #1;
    idle();
    sweep_pixels("R4 table after unstrobed write");
    chk("R4 mode after unstrobed write", mode_out, exp_mode);
  endtask

  task automatic t_dout_idle();
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_sel = 5'd0; host_din = exp_mode; #1;
    chk("R6 dout during write", host_dout, 8'h00);
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0; host_sel = 5'd2; #1;
    chk("R6 dout with strobe low", host_dout, 8'h00);
    idle();
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    for (int s = 17; s < 32; s++) host_write(5'(s), 8'hFF);
    sweep_pixels("R8 table after unmapped writes");
    chk("R8 mode after unmapped writes", mode_out, exp_mode);
    host_read(5'd20, d);
    chk("R8 unmapped read", d, 8'h00);
    host_read(5'd31, d);
    chk("R8 top unmapped read", d, 8'h00);
  endtask

  task automatic t_same_cycle();
    pix_idx = 4'd9;
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_sel = 5'd10; host_din = 8'h2A;
    #1;
    chk("R7 old color before storing edge", {2'b00, pix_color}, {2'b00, exp_pal[9]});
    @(posedge clk); #0.5;
    exp_pal[9] = 6'h2A;
    chk("R7 new color after storing edge", {2'b00, pix_color}, 8'h2A);
    idle();
    pix_idx = 4'd8; #0.2;
    chk("R3 neighbour unchanged", {2'b00, pix_color}, {2'b00, exp_pal[8]});
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_pal[i] = '0;
    exp_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_mode();
    t_palette();
    t_no_cs();
    t_dout_idle();
    t_unmapped();
    t_same_cycle();
    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) exp_pal[i] = '0;
    exp_mode = '0;
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule